// File: doc/BRIEF.md
# Configurable PLD Macrocell

This block is one logic cell of a small programmable logic device. A set of product terms is built from the cell's array inputs. Each term ANDs any chosen mix of true and complemented inputs. The terms are ORed into a sum. That sum, or its two halves, drives one storage element. Static configuration inputs make the element behave as a D, T, JK or SR flip-flop, or take it out of the output path so that the cell is purely combinational.

The element is clocked by the global clock or by a dedicated clock product term built from the array inputs, chosen per cell. An asynchronous clear forces it to zero. The cell has two results: the pin output and the feedback signal returned to the array. Each picks its own source and its own polarity.

All inputs are plain levels. The configuration pins are expected to be held static while the cell operates. The block has no handshake, because every input is sampled either continuously or at the selected clock edge.

Top module: `mcell`

## Requirements
- R1: Product term g is high only when at least one literal is enabled and every enabled literal is met. Bit g*N_IN+i of `pt_true_i` needs input i high, and the same bit of `pt_comp_i` needs input i low. A term with no enabled literal is 0.
- R2: The full sum is the OR of all N_PT terms. The set/J group is the OR of terms 0 to N_PT/2-1, and the reset/K group is the OR of terms N_PT/2 to N_PT-1.
- R3: With `mode_i`=0 (D), the register loads the full sum on each active clock edge.
- R4: With `mode_i`=1 (T), the register inverts on an active edge when the full sum is 1, and holds when it is 0.
- R5: With `mode_i`=2 (JK), using J = set group and K = reset group: J=K=1 inverts, J alone loads 1, K alone loads 0, and neither holds.
- R6: With `mode_i`=3 (SR), using S = set group and R = reset group: R loads 0 whether or not S is high, S alone loads 1, and neither holds.
- R7: With `mode_i`=4 (bypass; codes 5 to 7 act the same), the register holds its value and the output path carries the full sum.
- R8: With `clk_sel_i`=0 the register acts on rising edges of `clk_i`. With `clk_sel_i`=1 it acts on rising edges of the clock product term, which is built from `ck_true_i`/`ck_comp_i` under the R1 rules, and `clk_i` has no effect.
- R9: `clr_i` is active high and asynchronous. While it is high the register is 0 in every mode.
- R10: `out_o` equals the register value (modes 0 to 3) or the full sum (bypass), XOR `out_inv_i`.
- R11: `fb_o` equals the register value when `fb_reg_i`=1 or the full sum when it is 0, XOR `fb_inv_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Global clock |
| clr_i | input | 1 | Asynchronous clear, active high |
| arr_i | input | N_IN | Array inputs |
| pt_true_i | input | N_PT*N_IN | True-literal enables, N_IN bits per term |
| pt_comp_i | input | N_PT*N_IN | Complement-literal enables, N_IN bits per term |
| ck_true_i | input | N_IN | True-literal enables of the clock term |
| ck_comp_i | input | N_IN | Complement-literal enables of the clock term |
| mode_i | input | 3 | Register mode: 0 D, 1 T, 2 JK, 3 SR, 4 to 7 bypass |
| clk_sel_i | input | 1 | 0 global clock, 1 clock product term |
| out_inv_i | input | 1 | Invert the output path |
| fb_reg_i | input | 1 | Feedback from register (1) or sum (0) |
| fb_inv_i | input | 1 | Invert the feedback path |
| out_o | output | 1 | Cell output |
| fb_o | output | 1 | Feedback to the array |

## Verification
The clocked properties sample on the selected cell clock. They rely on three conditions. First, the data literals and the mode must not change at the same instant as a rising edge of that clock. Second, `clr_i` must change only between edges and stay high across at least one edge. Third, when the clock term is in use, its input is not shared with any data term.

The stimulus meets these conditions. It reserves the top array input for the clock term and keeps it out of every data mask. It changes data and configuration one time unit after a global edge, and raises the clock input half a unit later. It raises and drops the clear just after global edges.

// File: rtl/mcell_pkg.sv
package mcell_pkg;
  typedef enum logic [2:0] {
    MODE_D   = 3'd0,
    MODE_T   = 3'd1,
    MODE_JK  = 3'd2,
    MODE_SR  = 3'd3,
    MODE_BYP = 3'd4
  } reg_mode_e;
endpackage

// File: rtl/mcell_pterm.sv
// One product term: AND of enabled true/complement literals, 0 when empty.
module mcell_pterm #(
  parameter int N_IN = 8
) (
  input  logic [N_IN-1:0] arr_i,
  input  logic [N_IN-1:0] true_en_i,
  input  logic [N_IN-1:0] comp_en_i,
  output logic            term_o
);
  logic [N_IN-1:0] lit_ok;
  logic            any_lit;

  always_comb begin
    for (int i = 0; i < N_IN; i++) begin
      lit_ok[i] = (~true_en_i[i] | arr_i[i]) & (~comp_en_i[i] | ~arr_i[i]);
    end
    any_lit = |(true_en_i | comp_en_i);
    term_o  = any_lit & (&lit_ok);
  end
endmodule

// File: rtl/mcell_or_split.sv
// Fixed OR plane: full sum plus lower/upper half groups.
module mcell_or_split #(
  parameter int N_PT = 8
) (
  input  logic [N_PT-1:0] terms_i,
  output logic            sum_o,
  output logic            set_o,
  output logic            rst_o
);
  localparam int HALF = N_PT / 2;

  assign sum_o = |terms_i;
  assign set_o = |terms_i[HALF-1:0];
  assign rst_o = |terms_i[N_PT-1:HALF];
endmodule

// File: rtl/mcell_ff.sv
// Reconfigurable storage element with asynchronous clear.
module mcell_ff
  import mcell_pkg::*;
(
  input  logic      clk_i,
  input  logic      clr_i,
  input  reg_mode_e mode_i,
  input  logic      sum_i,
  input  logic      set_i,
  input  logic      rst_i,
  output logic      q_o
);
  logic nxt;

  always_comb begin
    nxt = q_o;
    unique case (mode_i)
      MODE_D:  nxt = sum_i;
      MODE_T:  nxt = q_o ^ sum_i;
      MODE_JK: begin
        case ({set_i, rst_i})
          2'b10:   nxt = 1'b1;
          2'b01:   nxt = 1'b0;
          2'b11:   nxt = ~q_o;
          default: nxt = q_o;
        endcase
      end
      MODE_SR: begin
        if (rst_i)      nxt = 1'b0;
        else if (set_i) nxt = 1'b1;
        else            nxt = q_o;
      end
      default: nxt = q_o;
    endcase
  end

  always_ff @(posedge clk_i or posedge clr_i) begin
    if (clr_i) q_o <= 1'b0;
    else       q_o <= nxt;
  end
endmodule

// File: rtl/mcell.sv
module mcell
  import mcell_pkg::*;
#(
  parameter int N_IN = 8,
  parameter int N_PT = 8
) (
  input  logic                 clk_i,
  input  logic                 clr_i,
  input  logic [N_IN-1:0]      arr_i,
  input  logic [N_PT*N_IN-1:0] pt_true_i,
  input  logic [N_PT*N_IN-1:0] pt_comp_i,
  input  logic [N_IN-1:0]      ck_true_i,
  input  logic [N_IN-1:0]      ck_comp_i,
  input  logic [2:0]           mode_i,
  input  logic                 clk_sel_i,
  input  logic                 out_inv_i,
  input  logic                 fb_reg_i,
  input  logic                 fb_inv_i,
  output logic                 out_o,
  output logic                 fb_o
);
  logic [N_PT-1:0] terms;
  logic            ck_term;
  logic            mclk;
  logic            sum_all;
  logic            set_grp;
  logic            rst_grp;
  logic            q_r;
  logic            is_byp;
  reg_mode_e       mode;

  assign mode   = (mode_i > 3'd4) ? MODE_BYP : reg_mode_e'(mode_i);
  assign is_byp = (mode == MODE_BYP);

  for (genvar g = 0; g < N_PT; g++) begin : g_pt
    mcell_pterm #(.N_IN(N_IN)) pt_i (
      .arr_i     (arr_i),
      .true_en_i (pt_true_i[g*N_IN +: N_IN]),
      .comp_en_i (pt_comp_i[g*N_IN +: N_IN]),
      .term_o    (terms[g])
    );
  end

  mcell_pterm #(.N_IN(N_IN)) ck_pt_i (
    .arr_i     (arr_i),
    .true_en_i (ck_true_i),
    .comp_en_i (ck_comp_i),
    .term_o    (ck_term)
  );

  mcell_or_split #(.N_PT(N_PT)) or_i (
    .terms_i (terms),
    .sum_o   (sum_all),
    .set_o   (set_grp),
    .rst_o   (rst_grp)
  );

  assign mclk = clk_sel_i ? ck_term : clk_i;

  mcell_ff ff_i (
    .clk_i  (mclk),
    .clr_i  (clr_i),
    .mode_i (mode),
    .sum_i  (sum_all),
    .set_i  (set_grp),
    .rst_i  (rst_grp),
    .q_o    (q_r)
  );

  assign out_o = (is_byp ? sum_all : q_r) ^ out_inv_i;
  assign fb_o  = (fb_reg_i ? q_r : sum_all) ^ fb_inv_i;
endmodule

// File: rtl/mcell_chk.sv
module mcell_chk (
  input logic       clk_i,
  input logic       mclk,
  input logic       clr_i,
  input logic [2:0] mode_i,
  input logic       sum,
  input logic       set,
  input logic       rst,
  input logic       q
);
  assert_d_load_R3: assert property (@(posedge mclk) disable iff (clr_i)
    (mode_i == 3'd0) |=> (q == $past(sum)));

  assert_t_toggle_R4: assert property (@(posedge mclk) disable iff (clr_i)
    (mode_i == 3'd1 && sum) |=> (q != $past(q)));

  assert_t_hold_R4: assert property (@(posedge mclk) disable iff (clr_i)
    (mode_i == 3'd1 && !sum) |=> (q == $past(q)));

  assert_jk_set_R5: assert property (@(posedge mclk) disable iff (clr_i)
    (mode_i == 3'd2 && set && !rst) |=> q);

  assert_jk_toggle_R5: assert property (@(posedge mclk) disable iff (clr_i)
    (mode_i == 3'd2 && set && rst) |=> (q != $past(q)));

  assert_sr_rst_wins_R6: assert property (@(posedge mclk) disable iff (clr_i)
    (mode_i == 3'd3 && rst) |=> !q);

  assert_byp_hold_R7: assert property (@(posedge mclk) disable iff (clr_i)
    (mode_i >= 3'd4) |=> $stable(q));

  assert_clear_R9: assert property (@(posedge clk_i)
    clr_i |-> !q);
endmodule

bind mcell mcell_chk chk_i (
  .clk_i  (clk_i),
  .mclk   (mclk),
  .clr_i  (clr_i),
  .mode_i (mode_i),
  .sum    (sum_all),
  .set    (set_grp),
  .rst    (rst_grp),
  .q      (q_r)
);

// File: tb/mcell_tb_top.sv
`timescale 1ns/1ps
module mcell_tb_top;
  localparam int N_IN = 8;
  localparam int N_PT = 8;
  localparam int MW   = N_PT * N_IN;
  localparam int HALF = N_PT / 2;

  logic          clk = 1'b0;
  logic          clr;
  logic [N_IN-1:0] arr;
  logic [MW-1:0] pt_t, pt_c;
  logic [N_IN-1:0] ck_t, ck_c;
  logic [2:0]    mode;
  logic          clk_sel, out_inv, fb_reg, fb_inv;
  logic          out_o, fb_o;

  int    n_checks = 0;
  int    n_errs   = 0;
  bit    cmp_en   = 0;
  string cur_tag  = "R9";

  always #2.5 clk = ~clk;

  mcell #(.N_IN(N_IN), .N_PT(N_PT)) dut_i (
    .clk_i(clk), .clr_i(clr), .arr_i(arr), .pt_true_i(pt_t), .pt_comp_i(pt_c),
    .ck_true_i(ck_t), .ck_comp_i(ck_c), .mode_i(mode), .clk_sel_i(clk_sel),
    .out_inv_i(out_inv), .fb_reg_i(fb_reg), .fb_inv_i(fb_inv),
    .out_o(out_o), .fb_o(fb_o)
  );

  // ---------------- behavioural reference ----------------
  function automatic logic f_term(input logic [N_IN-1:0] a, input logic [N_IN-1:0] t,
                                  input logic [N_IN-1:0] c);
    logic r = 1'b0;
    for (int i = 0; i < N_IN; i++) if (t[i] || c[i]) r = 1'b1;
    for (int i = 0; i < N_IN; i++) begin
      if (t[i] && !a[i]) r = 1'b0;
      if (c[i] &&  a[i]) r = 1'b0;
    end
    return r;
  endfunction

  function automatic logic f_group(input logic [N_IN-1:0] a, input logic [MW-1:0] t,
                                   input logic [MW-1:0] c, input int lo, input int hi);
    logic r = 1'b0;
    for (int g = lo; g < hi; g++) r = r | f_term(a, t[g*N_IN +: N_IN], c[g*N_IN +: N_IN]);
    return r;
  endfunction

  logic m_sum, m_j, m_k, m_ck, m_clk, m_q;
  logic e_out, e_fb;
  assign m_sum = f_group(arr, pt_t, pt_c, 0, N_PT);
  assign m_j   = f_group(arr, pt_t, pt_c, 0, HALF);
  assign m_k   = f_group(arr, pt_t, pt_c, HALF, N_PT);
  assign m_ck  = f_term(arr, ck_t, ck_c);
  assign m_clk = clk_sel ? m_ck : clk;
  assign e_out = ((mode >= 3'd4) ? m_sum : m_q) ^ out_inv;
  assign e_fb  = (fb_reg ? m_q : m_sum) ^ fb_inv;

  always @(posedge m_clk or posedge clr) begin
    if (clr) m_q <= 1'b0;
    else begin
      case (mode)
        3'd0: m_q <= m_sum;
        3'd1: if (m_sum) m_q <= ~m_q;
        3'd2: begin
          if (m_j && m_k) m_q <= ~m_q;
          else if (m_j)   m_q <= 1'b1;
          else if (m_k)   m_q <= 1'b0;
        end
        3'd3: begin
          if (m_k)      m_q <= 1'b0;
          else if (m_j) m_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  // ---------------- checking ----------------
  task automatic check(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      check({cur_tag, " R10 out"}, out_o, e_out);
      check({cur_tag, " R11 fb"}, fb_o, e_fb);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  function automatic logic [MW-1:0] rnd_mask();
    logic [MW-1:0] m = '0;
    for (int g = 0; g < N_PT; g++)
      for (int i = 0; i < N_IN - 1; i++) m[g*N_IN+i] = ($urandom_range(3) == 0);
    return m;
  endfunction

  task automatic run_phase(input string tag, input int md, input bit cs, input bit inv,
                           input bit fr, input bit fi, input int cycles);
    step();
    cur_tag = tag; mode = 3'(md); clk_sel = cs; out_inv = inv; fb_reg = fr; fb_inv = fi;
    pt_t = rnd_mask(); pt_c = rnd_mask();
    for (int n = 0; n < cycles; n++) begin
      step();
      if (n % 20 == 19) begin pt_t = rnd_mask(); pt_c = rnd_mask(); end
      arr = {1'b0, 7'($urandom())};
      if (cs) begin #0.5; arr[N_IN-1] = 1'b1; end
    end
  endtask

  // ---------------- stimulus ----------------
  initial begin
    clr = 1'b1; arr = '0; pt_t = '0; pt_c = '0;
    ck_t = '0; ck_t[N_IN-1] = 1'b1; ck_c = '0;
    mode = 3'd0; clk_sel = 1'b0; out_inv = 1'b0; fb_reg = 1'b1; fb_inv = 1'b0;
    repeat (3) step();
    check("R9 reset out", out_o, 1'b0);
    out_inv = 1'b1; #0.5;
    check("R10 inverted reset out", out_o, 1'b1);
    fb_inv = 1'b1; #0.5;
    check("R11 inverted reset fb", fb_o, 1'b1);
    out_inv = 1'b0; fb_inv = 1'b0;
    cmp_en = 1;
    step(); clr = 1'b0;

    // R1: empty terms, conflicting literals, mixed literals (bypass)
    cur_tag = "R1"; mode = 3'd4; arr = 8'h7f; #0.5;
    check("R1 empty terms give 0", out_o, 1'b0);
    pt_t[0] = 1'b1; pt_c[0] = 1'b1; #0.5;
    check("R1 x and not x gives 0", out_o, 1'b0);
    pt_c[0] = 1'b0; pt_c[1] = 1'b1; arr = 8'h01; #0.5;
    check("R1 a and not b gives 1", out_o, 1'b1);
    // R2: upper term alone reaches the full sum
    cur_tag = "R2"; pt_t = '0; pt_c = '0; pt_t[7*N_IN+2] = 1'b1; arr = 8'h04; #0.5;
    check("R2 top term in sum", out_o, 1'b1);
    arr = 8'h00; #0.5;
    check("R2 top term off", out_o, 1'b0);

    // R6: SR with set term 0 on bit0, reset term HALF on bit1
    step();
    cur_tag = "R6"; mode = 3'd3; pt_t = '0; pt_c = '0;
    pt_t[0] = 1'b1; pt_t[HALF*N_IN+1] = 1'b1; arr = 8'h01;
    step(); check("R6 set", out_o, 1'b1);
    arr = 8'h03; step(); check("R6 both gives reset", out_o, 1'b0);
    arr = 8'h00; step(); check("R6 hold", out_o, 1'b0);
    // R5: JK toggle
    cur_tag = "R5"; mode = 3'd2; arr = 8'h03;
    step(); check("R5 toggle up", out_o, 1'b1);
    step(); check("R5 toggle down", out_o, 1'b0);
    arr = 8'h01; step(); check("R5 J loads 1", out_o, 1'b1);
    arr = 8'h00; step(); check("R5 hold", out_o, 1'b1);
    // R9: clear while the register holds 1
    cur_tag = "R9"; mode = 3'd0; arr = 8'h01; step();
    @(posedge clk); #1; clr = 1'b1; #0.5;
    check("R9 async clear", out_o, 1'b0);
    step(); step(); clr = 1'b0;
    // R8: array clock ignores the global clock
    cur_tag = "R8"; clk_sel = 1'b1; arr = 8'h01;
    step(); step();
    check("R8 no global clocking", out_o, 1'b0);
    #0.5; arr[N_IN-1] = 1'b1; #0.5;
    check("R8 array clock edge loads", out_o, 1'b1);
    step(); arr = 8'h00; clk_sel = 1'b0; step();

    // Random sweeps over every mode, both clock sources and both polarities
    for (int md = 0; md < 5; md++) begin
      for (int cs = 0; cs < 2; cs++) begin
        string base;
        case (md)
          0: base = "R3"; 1: base = "R4"; 2: base = "R5"; 3: base = "R6"; default: base = "R7";
        endcase
        if (cs == 1) base = {base, " R8"};
        run_phase(base, md, bit'(cs), bit'((md + cs) % 2), bit'(cs), bit'(md % 2), 150);
      end
    end

    step(); cmp_en = 0;
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_checks++; n_errs++;
    $display("FAIL watchdog expired t=%0t", $time);
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end
endmodule